// File: doc/BRIEF.md
# Translation Lookaside Buffer with Invalidation

This block is a small fully associative store of recent translations from virtual pages to physical frames. It sits in front of a page-table walker. When a lookup hits, the four-level walk is skipped. Each entry holds one translation for either a 4 KB page or a 2 MB page, and both sizes sit together in the same array. A lookup is answered one cycle after it is issued. The answer carries a hit flag, the translated physical address, and the permission bits of the matching entry. When the walker finishes a walk, it writes the result back through the refill port.

Two invalidation commands keep the array consistent with memory. The single-page command removes whatever entry covers a given virtual address. The flush command empties the whole array, and is raised when the root table base register is rewritten. A write that hits a page not yet marked dirty is answered as a miss. The walker can then set the dirty bit in memory and refill the entry. Refill first takes an entry that already overlaps the new page, then the lowest free entry, and otherwise a round-robin victim.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is empty: rsp_valid is low and every lookup answers rsp_hit=0.
- R2: A refill accepted in one cycle is visible to a lookup issued in any later cycle.
- R3: rsp_valid is high exactly in the cycle after a cycle with lk_req high. On a miss, rsp_hit, rsp_paddr and all permission outputs are 0.
- R4: A 4 KB entry hits when virtual address bits 47:12 equal its tag. The address is then {frame[39:0], va[11:0]}, 52 bits wide.
- R5: A 2 MB entry hits for any address whose bits 47:21 equal its tag. The address is then {frame[39:9], va[20:0]}. Frame bits 8:0 and tag bits 20:12 of a 2 MB entry have no effect.
- R6: A lookup with lk_write=1 that hits an entry whose dirty bit is 0 answers rsp_hit=0. A read of the same entry hits.
- R7: A single-page invalidate removes every entry that covers its address, each compared at its own page size. All other entries stay.
- R8: A flush removes every entry.
- R9: When an invalidate or a flush is raised in the same cycle as a refill, the refill is dropped.
- R10: A refill that overlaps no entry takes the lowest-indexed empty entry when one exists.
- R11: With all entries valid, a refill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset, advances by one after each such replacement, and wraps.
- R12: A refill removes every entry that overlaps it, with the overlap compared at the larger of the two page sizes, and takes the first such slot. A lookup therefore never matches two entries.
- R13: On a hit, rsp_writable, rsp_user, rsp_nx and rsp_large show the stored writable, user, no-execute and page-size bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_write | input | 1 | Lookup is for a write access |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_writable | output | 1 | Hit entry is writable |
| rsp_user | output | 1 | Hit entry is user accessible |
| rsp_nx | output | 1 | Hit entry is no-execute |
| rsp_large | output | 1 | Hit entry is a 2 MB page |
| fill_en | input | 1 | Refill from a completed walk |
| fill_vaddr | input | 48 | Virtual address of the refilled page |
| fill_large | input | 1 | Refilled page is 2 MB |
| fill_pfn | input | 40 | Physical frame number (address bits 51:12) |
| fill_writable | input | 1 | Writable bit for the new entry |
| fill_user | input | 1 | User bit for the new entry |
| fill_nx | input | 1 | No-execute bit for the new entry |
| fill_dirty | input | 1 | Dirty bit for the new entry |
| inv_en | input | 1 | Invalidate the entries covering inv_vaddr |
| inv_vaddr | input | 48 | Address to invalidate |
| flush_en | input | 1 | Flush all entries (root base rewritten) |

## Verification
The embedded assertions check several properties on every cycle:
- a lookup never matches two entries;
- a flush leaves no valid entry;
- an invalidate leaves no valid entry covering its address;
- a refill that collides with an invalidate or flush adds nothing;
- an accepted refill lands in a valid slot;
- a free slot is preferred over eviction;
- a clean-page write is answered as a miss.

Some behaviour can only be shown by the directed scenarios, because it depends on the data values and on the history of refills:
- the translated address for each page size, including the bits that are ignored;
- the order in which entries are evicted as the round-robin pointer advances and wraps;
- the reuse of an invalidated slot;
- the replacement of overlapping pages.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 48;
  localparam int PFN_W  = 40;
  localparam int OFF_SM = 12;
  localparam int OFF_LG = 21;
  localparam int VPN_W  = VA_W - OFF_SM;
  localparam int LVL_W  = OFF_LG - OFF_SM;
  localparam int PA_W   = PFN_W + OFF_SM;

  typedef struct packed {
    logic             vld;
    logic             big;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             wr;
    logic             usr;
    logic             nx;
    logic             dirty;
  } tlb_ent_t;

  // entry covers address, compared at the entry's own page size
  function automatic logic ent_covers(tlb_ent_t e, logic [VA_W-1:0] va);
    if (!e.vld) return 1'b0;
    if (e.big) return e.vpn[VPN_W-1:LVL_W] == va[VA_W-1:OFF_LG];
    return e.vpn == va[VA_W-1:OFF_SM];
  endfunction

  // entry overlaps a new page, compared at the larger of both sizes
  function automatic logic ent_overlaps(tlb_ent_t e, logic [VA_W-1:0] va, logic big);
    if (!e.vld) return 1'b0;
    if (e.big || big) return e.vpn[VPN_W-1:LVL_W] == va[VA_W-1:OFF_LG];
    return e.vpn == va[VA_W-1:OFF_SM];
  endfunction

  function automatic logic [PA_W-1:0] ent_xlate(tlb_ent_t e, logic [VA_W-1:0] va);
    if (e.big) return {e.pfn[PFN_W-1:LVL_W], va[OFF_LG-1:0]};
    return {e.pfn, va[OFF_SM-1:0]};
  endfunction
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
  import tlb_pkg::*;
(
  input  tlb_ent_t        ent,
  input  logic [VA_W-1:0] lk_va,
  input  logic [VA_W-1:0] inv_va,
  input  logic [VA_W-1:0] fill_va,
  input  logic            fill_big,
  output logic            lk_hit,
  output logic            inv_hit,
  output logic            dup_hit
);
  assign lk_hit  = ent_covers(ent, lk_va);
  assign inv_hit = ent_covers(ent, inv_va);
  assign dup_hit = ent_overlaps(ent, fill_va, fill_big);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx, free_idx;
  logic             any_dup, any_free, use_rr;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    any_dup  = 1'b0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i]) begin
        dup_idx = IDX_W'(i);
        any_dup = 1'b1;
      end
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign use_rr = !any_dup && !any_free;
  assign idx    = any_dup ? dup_idx : (any_free ? free_idx : rr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (take && use_rr)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && !any_dup && !(&valid_vec) |-> !valid_vec[idx]); // R10
  AST_PICK_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && (|dup_vec) |-> dup_vec[idx]); // R12
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [47:0]      lk_vaddr,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [51:0]      rsp_paddr,
  output logic             rsp_writable,
  output logic             rsp_user,
  output logic             rsp_nx,
  output logic             rsp_large,
  input  logic             fill_en,
  input  logic [47:0]      fill_vaddr,
  input  logic             fill_large,
  input  logic [39:0]      fill_pfn,
  input  logic             fill_writable,
  input  logic             fill_user,
  input  logic             fill_nx,
  input  logic             fill_dirty,
  input  logic             inv_en,
  input  logic [47:0]      inv_vaddr,
  input  logic             flush_en
);
  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match, inv_match, dup_match, valid_vec;
  logic [IDX_W-1:0]   vic_idx;
  tlb_ent_t           sel, new_ent;
  logic               lk_any, lk_good, fill_take;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_tag_cmp u_cmp (
      .ent     (ent_q[g]),
      .lk_va   (lk_vaddr),
      .inv_va  (inv_vaddr),
      .fill_va (fill_vaddr),
      .fill_big(fill_large),
      .lk_hit  (lk_match[g]),
      .inv_hit (inv_match[g]),
      .dup_hit (dup_match[g])
    );
    assign valid_vec[g] = ent_q[g].vld;
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) sel = tlb_ent_t'(sel | ent_q[i]);
  end

  assign lk_any    = |lk_match;
  assign lk_good   = lk_any && !(lk_write && !sel.dirty);
  assign fill_take = fill_en && !inv_en && !flush_en;

  always_comb begin
    new_ent       = '0;
    new_ent.vld   = 1'b1;
    new_ent.big   = fill_large;
    new_ent.vpn   = fill_vaddr[VA_W-1:OFF_SM];
    new_ent.pfn   = fill_pfn;
    new_ent.wr    = fill_writable;
    new_ent.usr   = fill_user;
    new_ent.nx    = fill_nx;
    new_ent.dirty = fill_dirty;
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_vic (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_vec(valid_vec),
    .dup_vec  (dup_match),
    .take     (fill_take),
    .idx      (vic_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (flush_en) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i].vld <= 1'b0;
    end else if (inv_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_match[i]) ent_q[i].vld <= 1'b0;
    end else if (fill_take) begin
      for (int i = 0; i < ENTRIES; i++)
        if (dup_match[i]) ent_q[i].vld <= 1'b0;
      ent_q[vic_idx] <= new_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      rsp_writable <= 1'b0;
      rsp_user     <= 1'b0;
      rsp_nx       <= 1'b0;
      rsp_large    <= 1'b0;
    end else begin
      rsp_valid    <= lk_req;
      rsp_hit      <= lk_req && lk_good;
      rsp_paddr    <= (lk_req && lk_good) ? ent_xlate(sel, lk_vaddr) : '0;
      rsp_writable <= lk_req && lk_good && sel.wr;
      rsp_user     <= lk_req && lk_good && sel.usr;
      rsp_nx       <= lk_req && lk_good && sel.nx;
      rsp_large    <= lk_req && lk_good && sel.big;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R12
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> valid_vec == '0); // R8
  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (valid_vec & $past(inv_match)) == '0); // R7
  AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && (inv_en || flush_en) |=> (valid_vec & ~$past(valid_vec)) == '0); // R9
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> valid_vec[$past(vic_idx)]); // R2
  AST_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && lk_write && lk_any && !sel.dirty |=> rsp_valid && !rsp_hit); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0 && !rsp_writable && !rsp_large); // R3
endmodule

// File: tb/tlb_cache_tb.sv
module tlb_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, lk_write = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_writable, rsp_user, rsp_nx, rsp_large;
  logic [51:0] rsp_paddr;
  logic        fill_en = 1'b0, fill_large = 1'b0;
  logic [47:0] fill_vaddr = '0;
  logic [39:0] fill_pfn = '0;
  logic        fill_writable = 1'b0, fill_user = 1'b0, fill_nx = 1'b0, fill_dirty = 1'b0;
  logic        inv_en = 1'b0, flush_en = 1'b0;
  logic [47:0] inv_vaddr = '0;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tlb_cache u_dut (.*);

  localparam logic [47:0] PG_BASE  = 48'h0000_1234_0000;
  localparam logic [39:0] FR_BASE  = 40'h00_000A_BC00;

  function automatic logic [47:0] pg(int k);
    return PG_BASE + 48'(k) * 48'h1000;
  endfunction
  function automatic logic [39:0] fr(int k);
    return FR_BASE + 40'(k);
  endfunction
  function automatic logic [51:0] pa_small(logic [39:0] f, logic [47:0] va);
    return (52'(f) << 12) + 52'(va & 48'hFFF);
  endfunction
  function automatic logic [51:0] pa_big(logic [39:0] f, logic [47:0] va);
    return ((52'(f) >> 9) << 21) + 52'(va % 48'h20_0000);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [47:0] va, logic wr);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr;
    @(negedge clk);
    lk_req = 1'b0; lk_write = 1'b0;
  endtask

  task automatic expect_hit(string req, logic [47:0] va, logic [51:0] pa);
    lookup(va, 1'b0);
    check(req, {rsp_valid, rsp_hit}, 2'b11);
    check(req, rsp_paddr, pa);
  endtask

  task automatic expect_miss(string req, logic [47:0] va);
    lookup(va, 1'b0);
    check(req, {rsp_valid, rsp_hit, rsp_paddr}, {2'b10, 52'h0});
  endtask

  task automatic refill(logic [47:0] va, logic big, logic [39:0] f,
                        logic w, logic u, logic x, logic d);
    @(negedge clk);
    fill_en = 1'b1; fill_vaddr = va; fill_large = big; fill_pfn = f;
    fill_writable = w; fill_user = u; fill_nx = x; fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic invalidate(logic [47:0] va);
    @(negedge clk);
    inv_en = 1'b1; inv_vaddr = va;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk);
    flush_en = 1'b1;
    @(negedge clk);
    flush_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", rsp_valid, 0);
    expect_miss("R1 empty after reset", pg(0));
  endtask

  task automatic t_timing();
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = pg(0);
    @(negedge clk);
    lk_req = 1'b0;
    check("R3 valid one cycle later", rsp_valid, 1);
    check("R3 miss outputs zero", {rsp_hit, rsp_writable, rsp_user, rsp_nx, rsp_large}, 0);
    @(negedge clk);
    check("R3 valid drops", rsp_valid, 0);
  endtask

  task automatic t_small();
    refill(pg(0), 1'b0, fr(0), 1, 1, 0, 1);
    expect_hit("R2 R4 small hit", pg(0) + 48'h5A7, pa_small(fr(0), pg(0) + 48'h5A7));
    check("R13 perms", {rsp_writable, rsp_user, rsp_nx, rsp_large}, 4'b1100);
    expect_miss("R4 neighbour page", pg(1));
  endtask

  task automatic t_large();
    logic [47:0] base = 48'h0000_7FC0_0000;
    logic [39:0] f = 40'h00_0012_31FF;
    refill(base + 48'h3000, 1'b1, f, 0, 0, 1, 1);
    expect_hit("R5 large hit", base + 48'h1A_BCDE, pa_big(f, base + 48'h1A_BCDE));
    check("R13 large perms", {rsp_writable, rsp_user, rsp_nx, rsp_large}, 4'b0011);
    expect_hit("R5 large low", base, pa_big(f, base));
    expect_miss("R5 next region", base + 48'h20_0000);
  endtask

  task automatic t_dirty();
    refill(pg(20), 1'b0, fr(20), 1, 0, 0, 0);
    lookup(pg(20), 1'b1);
    check("R6 clean write misses", {rsp_valid, rsp_hit}, 2'b10);
    expect_hit("R6 clean read hits", pg(20), pa_small(fr(20), pg(20)));
    refill(pg(20), 1'b0, fr(20), 1, 0, 0, 1);
    lookup(pg(20), 1'b1);
    check("R6 dirty write hits", {rsp_valid, rsp_hit}, 2'b11);
  endtask

  task automatic t_inval();
    invalidate(pg(0) + 48'h123);
    expect_miss("R7 invalidated page", pg(0));
    expect_hit("R7 other page kept", pg(20), pa_small(fr(20), pg(20)));
    invalidate(48'h0000_7FC0_0000 + 48'h1F_F000);
    expect_miss("R7 large removed", 48'h0000_7FC0_0000);
    expect_hit("R7 small still kept", pg(20), pa_small(fr(20), pg(20)));
  endtask

  task automatic t_flush();
    refill(pg(2), 1'b0, fr(2), 1, 1, 1, 1);
    flush_all();
    expect_miss("R8 flush page 20", pg(20));
    expect_miss("R8 flush page 2", pg(2));
  endtask

  task automatic t_priority();
    @(negedge clk);
    fill_en = 1'b1; fill_vaddr = pg(4); fill_large = 1'b0; fill_pfn = fr(4);
    fill_dirty = 1'b1; inv_en = 1'b1; inv_vaddr = pg(30);
    @(negedge clk);
    fill_en = 1'b0; inv_en = 1'b0;
    expect_miss("R9 fill dropped by invalidate", pg(4));
    @(negedge clk);
    fill_en = 1'b1; flush_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; flush_en = 1'b0;
    expect_miss("R9 fill dropped by flush", pg(4));
  endtask

  task automatic t_replace();
    flush_all();
    for (int k = 0; k < 8; k++) refill(pg(k), 1'b0, fr(k), 1, 0, 0, 1);
    for (int k = 0; k < 8; k++) expect_hit("R10 free slots filled", pg(k), pa_small(fr(k), pg(k)));
    refill(pg(8), 1'b0, fr(8), 1, 0, 0, 1);
    expect_miss("R11 first eviction slot 0", pg(0));
    for (int k = 1; k < 9; k++) expect_hit("R11 survivors", pg(k), pa_small(fr(k), pg(k)));
    invalidate(pg(3));
    refill(pg(9), 1'b0, fr(9), 1, 0, 0, 1);
    expect_hit("R10 reuse freed slot", pg(9), pa_small(fr(9), pg(9)));
    expect_hit("R10 pointer not used", pg(1), pa_small(fr(1), pg(1)));
    refill(pg(10), 1'b0, fr(10), 1, 0, 0, 1);
    expect_miss("R11 second eviction slot 1", pg(1));
    expect_hit("R11 slot 2 kept", pg(2), pa_small(fr(2), pg(2)));
    expect_hit("R11 new page", pg(10), pa_small(fr(10), pg(10)));
  endtask

  task automatic t_overlap();
    refill(pg(5), 1'b0, fr(50), 0, 1, 0, 1);
    expect_hit("R12 replaced frame", pg(5), pa_small(fr(50), pg(5)));
    check("R12 replaced perms", {rsp_writable, rsp_user}, 2'b01);
    expect_hit("R12 no eviction", pg(2), pa_small(fr(2), pg(2)));
    refill(pg(0), 1'b1, 40'h00_0044_4000, 1, 0, 0, 1);
    expect_hit("R12 large replaces all", pg(7) + 48'h10, pa_big(40'h00_0044_4000, pg(7) + 48'h10));
    check("R12 large flag", rsp_large, 1);
    refill(48'h0000_0000_5000, 1'b0, fr(60), 1, 0, 0, 1);
    expect_hit("R12 freed slot usable", 48'h0000_0000_5000, pa_small(fr(60), 48'h0000_0000_5000));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_small();
        t_large();
        t_dirty();
        t_inval();
        t_flush();
        t_priority();
        t_replace();
        t_overlap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule